// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Dead-Band Pair

This block generates one center-aligned PWM channel and a complementary output derived from it. An up-down time base counts from zero to a programmable period and back, so every pulse is symmetric about the period turning point. A compare value, taken from its input only at the two turning points, decides where the undelayed drive signal rises while counting up and falls while counting down. A dead-band stage then produces the output pair. It delays the rising edge of output A by a rising delay. It delays the falling edge of the drive signal by a falling delay, and output B is the inverse of that delayed signal. Both delays count either whole clocks or half clocks.

The time base is a two-state machine. `TB_UP` steps the counter up. It moves to `TB_DOWN` once the counter reaches the period. `TB_DOWN` steps the counter down and moves back to `TB_UP` after the zero point. Each dead-band path is a three-state machine. `DL_IDLE` waits for its input to go high. It moves to `DL_PASS` directly when the whole-clock part of the delay is at most one, and otherwise to `DL_WAIT`. `DL_WAIT` counts down the remaining clocks and moves to `DL_PASS` at zero. It returns to `DL_IDLE` if the input drops first, so the pulse is swallowed. `DL_PASS` lets the input through and returns to `DL_IDLE` when the input falls. An odd delay in half-clock mode adds one falling-edge retiming flop to the rising edge only.

Top module: `cpwm_deadband`

## Requirements
- R1: The counter runs 0,1,…,P,P-1,…,1,0 (P = `period`, P ≥ 1), so it repeats every 2·P clocks. `at_zero` is high while the count is 0 and `at_peak` is high while the count equals P. `at_peak` is high for a single cycle.
- R2: With zero delays and a compare value C (0 < C < P), the undelayed drive rises on the clock edge that ends the up-counting cycle with count C. It falls on the edge that ends the down-counting cycle with count C. Measured from the rising edge of `at_zero`, these two edges fall at (C+1) and (2P−C+1) clocks. The falling edge reaches `pwm_a` with no delay.
- R3: A new `cmp_wr` value takes effect only when the count is 0 or P. A value written while counting up, before the match, still leaves the rise at the old position. The fall then follows the new value.
- R4: With `half_en`=1, each unit of `red`/`fed` is half a clock. An odd value places the delayed edge on the falling clock edge.
- R5: With `half_en`=0, each unit of `red`/`fed` is one whole clock.
- R6: `pwm_b` is low while the drive is high. It falls on the edge where the drive rises, and it rises `fed` units after the drive falls.
- R7: A delay of 0 passes the edge through with no added shift.
- R8: The delayed rise of `pwm_a` may lie beyond the `at_peak` instant and keeps its exact offset there.
- R9: If the drive falls before the rising delay expires (delay ≥ pulse width), `pwm_a` stays low for that pulse.
- R10: An active compare value of 0, or one ≥ P, holds the drive low with no edges. `pwm_a` then stays low and `pwm_b` stays high.
- R11: `pol_low`=1 inverts both outputs (active-low complementary). `pol_low`=0 is active-high.
- R12: The two outputs are never active at the same time (both high when `pol_low`=0, both low when `pol_low`=1).
- R13: During reset `pwm_a` is low and `at_zero` is high. With a nonzero `fed`, `pwm_b` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | CW | Turning-point count P |
| cmp_wr | input | CW | Compare value, loaded at count 0 or P |
| red | input | DW | Rising-edge delay for output A |
| fed | input | DW | Falling-edge delay (rise of output B) |
| half_en | input | 1 | Delays count in half clocks when 1 |
| pol_low | input | 1 | 1 inverts both outputs |
| pwm_a | output | 1 | Delayed PWM output A |
| pwm_b | output | 1 | Complementary delayed output B |
| at_zero | output | 1 | Count equals zero |
| at_peak | output | 1 | Count equals period |

## Verification
A time-base state that is stuck or wrong moves `at_peak` and `at_zero` off their 2·P cadence within one period. Every edge offset measured from `at_zero` would then be off by whole clocks. A dead-band machine left in `DL_PASS` or `DL_WAIT` after its input drops shows up one pulse later as an early or missing rise on `pwm_a` or `pwm_b`, or as both outputs active together. A wrong choice of retiming flop shifts an edge by exactly half a clock. For this reason the edge times are checked at sub-clock resolution against offsets from the zero strobe.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [0:0] {TB_UP, TB_DOWN} tb_state_e;
    typedef enum logic [1:0] {DL_IDLE, DL_WAIT, DL_PASS} dl_state_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          counting_up,
    output logic          at_zero,
    output logic          at_peak
);
    tb_state_e     st, st_n;
    logic [CW-1:0] cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TB_DOWN;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            TB_UP: begin
                if (cnt >= period) begin
                    st_n  = TB_DOWN;
                    cnt_n = (cnt == '0) ? '0 : cnt - CW'(1);
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            TB_DOWN: begin
                if (cnt == '0) begin
                    if (period != '0) begin
                        st_n  = TB_UP;
                        cnt_n = CW'(1);
                    end
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            default: begin
                st_n  = TB_DOWN;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        counting_up = (st == TB_UP);
        at_zero     = (cnt == '0);
        at_peak     = (cnt == period);
    end
endmodule

// File: rtl/cpwm_action.sv
module cpwm_action #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          counting_up,
    input  logic          at_zero,
    input  logic          at_peak,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cmp_wr,
    output logic          a_raw
);
    logic [CW-1:0] cmp_act;
    logic          cmp_ok;
    logic          hit;

    assign cmp_ok = (cmp_act != '0) && (cmp_act < period);
    assign hit    = (cnt == cmp_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_act <= '0;
        end else if (at_zero || at_peak) begin
            cmp_act <= cmp_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_raw <= 1'b0;
        end else if (!cmp_ok) begin
            a_raw <= 1'b0;
        end else if (hit && counting_up) begin
            a_raw <= 1'b1;
        end else if (hit && !counting_up) begin
            a_raw <= 1'b0;
        end
    end
endmodule

// File: rtl/cpwm_edge_dly.sv
module cpwm_edge_dly
    import cpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig,
    input  logic [DW-1:0] dly,
    input  logic          half_en,
    output logic          q
);
    dl_state_e     st, st_n;
    logic [DW-1:0] tmr, tmr_n;
    logic [DW-1:0] whole;
    logic          half_bit;
    logic          qc;
    logic          qn;

    assign whole    = half_en ? (dly >> 1) : dly;
    assign half_bit = half_en & dly[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DL_IDLE;
            tmr <= '0;
        end else begin
            st  <= st_n;
            tmr <= tmr_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st;
        tmr_n = tmr;
        unique case (st)
            DL_IDLE: begin
                if (sig) begin
                    if (whole <= DW'(1)) begin
                        st_n = DL_PASS;
                    end else begin
                        st_n  = DL_WAIT;
                        tmr_n = whole - DW'(2);
                    end
                end
            end
            DL_WAIT: begin
                if (!sig)             st_n = DL_IDLE;
                else if (tmr == '0)   st_n = DL_PASS;
                else                  tmr_n = tmr - DW'(1);
            end
            DL_PASS: begin
                if (!sig) st_n = DL_IDLE;
            end
            default: st_n = DL_IDLE;
        endcase
    end

    // outputs: whole-clock part, then optional half-clock retime of the rise
    assign qc = sig && ((whole == '0) || (st == DL_PASS));

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) qn <= 1'b0;
        else        qn <= qc;
    end

    assign q = half_bit ? (qc & qn) : qc;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cmp_wr,
    input  logic [DW-1:0] red,
    input  logic [DW-1:0] fed,
    input  logic          half_en,
    input  logic          pol_low,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          at_zero,
    output logic          at_peak
);
    localparam int NPATH = 2;

    logic [CW-1:0]    cnt;
    logic             counting_up;
    logic             a_raw;
    logic [NPATH-1:0] path_sig;
    logic [NPATH-1:0] path_q;
    logic [DW-1:0]    path_dly [NPATH];

    cpwm_timebase #(.CW(CW)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .period      (period),
        .cnt         (cnt),
        .counting_up (counting_up),
        .at_zero     (at_zero),
        .at_peak     (at_peak)
    );

    cpwm_action #(.CW(CW)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt         (cnt),
        .counting_up (counting_up),
        .at_zero     (at_zero),
        .at_peak     (at_peak),
        .period      (period),
        .cmp_wr      (cmp_wr),
        .a_raw       (a_raw)
    );

    // path 0 delays the drive's rise; path 1 delays the rise of its inverse,
    // which is the inverse of the drive with its fall delayed
    assign path_sig    = {~a_raw, a_raw};
    assign path_dly[0] = red;
    assign path_dly[1] = fed;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        cpwm_edge_dly #(.DW(DW)) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig     (path_sig[g]),
            .dly     (path_dly[g]),
            .half_en (half_en),
            .q       (path_q[g])
        );
    end

    assign pwm_a = path_q[0] ^ pol_low;
    assign pwm_b = path_q[1] ^ pol_low;
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] period,
    input logic [DW-1:0] red,
    input logic          pol_low,
    input logic          a_raw,
    input logic          pwm_a,
    input logic          pwm_b,
    input logic          at_zero,
    input logic          at_peak
);
    // R1: strobes are exclusive while the period is nonzero
    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> !(at_zero && at_peak));

    // R1: the peak strobe lasts one cycle unless the period was rewritten
    p_peak_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (at_peak && period != '0) |=> (!at_peak || period != $past(period)));

    // R2: the drive's fall reaches output A at once
    p_fall_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_low && $fell(a_raw)) |-> !pwm_a);

    // R7: zero rising delay follows the drive exactly
    p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (red == '0 && !pol_low) |-> (pwm_a == a_raw));

    // R9: output A never rises without the drive high
    p_rise_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_low && $rose(pwm_a)) |-> a_raw);

    // R12: never both outputs active
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_a ^ pol_low) && (pwm_b ^ pol_low)));
endmodule

bind cpwm_deadband cpwm_checker #(.CW(CW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (period),
    .red     (red),
    .pol_low (pol_low),
    .a_raw   (a_raw),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .at_zero (at_zero),
    .at_peak (at_peak)
);

// File: tb/sim_cpwm_deadband.sv
`timescale 1ns/1ps
module sim_cpwm_deadband;
    localparam int  CW  = 16;
    localparam int  DW  = 8;
    localparam real TCK = 5.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] period;
    logic [CW-1:0] cmp_wr;
    logic [DW-1:0] red;
    logic [DW-1:0] fed;
    logic          half_en;
    logic          pol_low;
    logic          pwm_a, pwm_b, at_zero, at_peak;

    int  checks = 0;
    int  errors = 0;
    int  overlaps = 0;
    bit  done = 1'b0;
    real ta_r, ta_f, tb_r, tb_f;
    int  na_r = 0, na_f = 0, nb_r = 0, nb_f = 0;

    always #2.5 clk = ~clk;

    cpwm_deadband #(.CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .period(period), .cmp_wr(cmp_wr),
        .red(red), .fed(fed), .half_en(half_en), .pol_low(pol_low),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .at_zero(at_zero), .at_peak(at_peak)
    );

    always @(posedge pwm_a) begin ta_r = $realtime; na_r++; end
    always @(negedge pwm_a) begin ta_f = $realtime; na_f++; end
    always @(posedge pwm_b) begin tb_r = $realtime; nb_r++; end
    always @(negedge pwm_b) begin tb_f = $realtime; nb_f++; end

    // R12 monitor, sampled after both clock edges
    always @(clk) begin
        #1;
        if (rst_n && !done && (pwm_a ^ pol_low) && (pwm_b ^ pol_low)) overlaps++;
    end

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_real(string req, string what, real act, real exp);
        checks++;
        if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
            errors++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic configure(int p, int c, int r, int f, bit h, bit pl);
        @(negedge clk);
        period  = CW'(p);
        cmp_wr  = CW'(c);
        red     = DW'(r);
        fed     = DW'(f);
        half_en = h;
        pol_low = pl;
        repeat (2) @(posedge at_zero);
    endtask

    // one period window from a zero strobe; offsets in clocks, negative = no edge
    task automatic measure(string req, int p, real ear, real eaf, real ebr, real ebf);
        real tz;
        int  s_ar, s_af, s_br, s_bf;
        @(posedge at_zero);
        tz = $realtime;
        s_ar = na_r; s_af = na_f; s_br = nb_r; s_bf = nb_f;
        repeat (2 * p) @(posedge clk);
        #1;
        if (ear < 0) chk_int(req, "A rise count", na_r - s_ar, 0);
        else begin
            chk_int(req, "A rise count", na_r - s_ar, 1);
            chk_real(req, "A rise offset", (ta_r - tz) / TCK, ear);
        end
        if (eaf < 0) chk_int(req, "A fall count", na_f - s_af, 0);
        else begin
            chk_int(req, "A fall count", na_f - s_af, 1);
            chk_real(req, "A fall offset", (ta_f - tz) / TCK, eaf);
        end
        if (ebr < 0) chk_int(req, "B rise count", nb_r - s_br, 0);
        else begin
            chk_int(req, "B rise count", nb_r - s_br, 1);
            chk_real(req, "B rise offset", (tb_r - tz) / TCK, ebr);
        end
        if (ebf < 0) chk_int(req, "B fall count", nb_f - s_bf, 0);
        else begin
            chk_int(req, "B fall count", nb_f - s_bf, 1);
            chk_real(req, "B fall offset", (tb_f - tz) / TCK, ebf);
        end
    endtask

    task automatic t_reset;
        period = 20; cmp_wr = 10; red = 0; fed = 4; half_en = 0; pol_low = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_int("R13", "pwm_a in reset", int'(pwm_a), 0);
        chk_int("R13", "pwm_b in reset", int'(pwm_b), 0);
        chk_int("R13", "at_zero in reset", int'(at_zero), 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_counter;
        real t0, t1, t2;
        configure(20, 10, 0, 0, 0, 0);
        @(posedge at_zero); t0 = $realtime;
        @(posedge at_peak); t1 = $realtime;
        @(posedge at_zero); t2 = $realtime;
        chk_real("R1", "zero to peak P=20", (t1 - t0) / TCK, 20.0);
        chk_real("R1", "zero to zero P=20", (t2 - t0) / TCK, 40.0);
        @(posedge clk); #1;
        chk_int("R1", "peak strobe width", int'(at_peak), 0);
        configure(7, 3, 0, 0, 0, 0);
        @(posedge at_zero); t0 = $realtime;
        @(posedge at_peak); t1 = $realtime;
        @(posedge at_zero); t2 = $realtime;
        chk_real("R1", "zero to peak P=7", (t1 - t0) / TCK, 7.0);
        chk_real("R1", "zero to zero P=7", (t2 - t0) / TCK, 14.0);
    endtask

    task automatic t_basic;
        configure(20, 10, 0, 0, 0, 0);
        measure("R2 R7", 20, 11.0, 31.0, 31.0, 11.0);
        configure(20, 4, 0, 0, 0, 0);
        measure("R2 R7", 20, 5.0, 37.0, 37.0, 5.0);
    endtask

    task automatic t_full;
        configure(20, 10, 3, 4, 0, 0);
        measure("R5 R6", 20, 14.0, 31.0, 35.0, 11.0);
    endtask

    task automatic t_half;
        configure(20, 10, 5, 2, 1, 0);
        measure("R4 R6", 20, 13.5, 31.0, 32.0, 11.0);
        configure(20, 10, 1, 3, 1, 0);
        measure("R4", 20, 11.5, 31.0, 32.5, 11.0);
    endtask

    task automatic t_cross;
        configure(20, 10, 22, 0, 1, 0);
        measure("R8", 20, 22.0, 31.0, 31.0, 11.0);
        configure(20, 10, 23, 0, 1, 0);
        measure("R8", 20, 22.5, 31.0, 31.0, 11.0);
    endtask

    task automatic t_swallow;
        configure(20, 10, 19, 0, 0, 0);
        measure("R9", 20, 30.0, 31.0, 31.0, 11.0);
        configure(20, 10, 20, 0, 0, 0);
        measure("R9", 20, -1.0, -1.0, 31.0, 11.0);
        chk_int("R9", "pwm_a held low", int'(pwm_a), 0);
    endtask

    task automatic t_invalid;
        configure(20, 0, 0, 0, 0, 0);
        measure("R10 zero compare", 20, -1.0, -1.0, -1.0, -1.0);
        chk_int("R10", "pwm_a low, C=0", int'(pwm_a), 0);
        chk_int("R10", "pwm_b high, C=0", int'(pwm_b), 1);
        configure(20, 20, 0, 0, 0, 0);
        measure("R10 compare=P", 20, -1.0, -1.0, -1.0, -1.0);
        chk_int("R10", "pwm_a low, C=P", int'(pwm_a), 0);
        configure(20, 25, 0, 0, 0, 0);
        measure("R10 compare>P", 20, -1.0, -1.0, -1.0, -1.0);
        chk_int("R10", "pwm_b high, C>P", int'(pwm_b), 1);
    endtask

    task automatic t_polarity;
        configure(20, 10, 3, 4, 0, 1);
        measure("R11", 20, 31.0, 14.0, 11.0, 35.0);
    endtask

    task automatic t_shadow;
        real tz;
        int  s_ar, s_af;
        configure(20, 10, 0, 0, 0, 0);
        @(posedge at_zero);
        tz = $realtime;
        s_ar = na_r; s_af = na_f;
        repeat (3) @(negedge clk);
        cmp_wr = 5;
        repeat (38) @(posedge clk);
        #1;
        chk_int("R3", "rise count", na_r - s_ar, 1);
        chk_real("R3", "rise keeps old compare", (ta_r - tz) / TCK, 11.0);
        chk_int("R3", "fall count", na_f - s_af, 1);
        chk_real("R3", "fall uses new compare", (ta_f - tz) / TCK, 36.0);
        measure("R3 next period", 20, 6.0, 36.0, 36.0, 6.0);
    endtask

    task automatic finish_run;
        chk_int("R12", "overlap samples", overlaps, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_counter();
        t_basic();
        t_full();
        t_half();
        t_cross();
        t_swallow();
        t_invalid();
        t_polarity();
        t_shadow();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule